// File: doc/BRIEF.md
# Page Write Buffer Sequencer

This block sits behind a serial-bus front end of a byte-wide non-volatile store. It gathers the data bytes of one page write into a small buffer, then programs all of them into the storage array in one timed program cycle. The front end gives it three strobes. The first opens a write and carries the word address. The second delivers each data byte. The third marks the end of the transfer.

The page size is `2**PAGE_W` bytes. The in-page part of the address advances after every byte and wraps at the page edge, so a long transfer overwrites bytes it buffered earlier. Nothing reaches the array until the end strobe arrives. The array is then written through a wide port that carries one enable per byte. After that the block holds a busy flag for `WRITE_CYCLES` clock cycles and ignores all of its inputs. A protect input turns the upper half of the address space into read-only storage. A write aimed there is dropped without a trace.

The storage array is a plain synthesizable memory model that the top instantiates. It has an asynchronous read port, so its contents can be inspected.

Top module: `pwb_sequencer`

## Requirements
- R1: After reset, `busy` is 0, `progEn` is 0, `curAddr` is 0 and every array byte reads 0.
- R2: `startStrb` loads `curAddr` from `startAddr`. Each accepted `byteStrb` stores `byteData` at buffer slot `curAddr[PAGE_W-1:0]`, then adds one to those low bits modulo `2**PAGE_W`. Bits above `PAGE_W` never change except on `startStrb`. This holds whether the write is later committed or dropped.
- R3: When more than `2**PAGE_W` bytes arrive before the end strobe, the later bytes replace the earlier ones in the same slots, and only the last value for each slot is programmed.
- R4: The array does not change before `stopStrb`. A `stopStrb` that follows at least one byte causes exactly one program of the buffered bytes.
- R5: A committed write raises `busy` in the cycle after `stopStrb` and holds it for exactly `WRITE_CYCLES` cycles.
- R6: While `busy` is 1, `startStrb`, `byteStrb` and `stopStrb` have no effect on `curAddr` or on the array.
- R7: If `writeProtect` is 1 when `stopStrb` arrives and `curAddr` bit `ADDR_W-1` is 1, the write is dropped: `busy` stays 0 and the array is unchanged. With `writeProtect` at 1, lower-half pages are still written, and with `writeProtect` at 0 the upper half is writable.
- R8: Bit i of `progByteEn` is 1 only for page slots that received a byte. Array bytes in slots that received no byte keep their old value.
- R9: A `stopStrb` that follows a `startStrb` with no bytes in between starts no program cycle, and `busy` stays 0.
- R10: After a write, `curAddr` equals the last written address plus one, with the wrap taken inside the page.
- R11: `progEn` is high for exactly one cycle, which is the first busy cycle. In that cycle, `progAddr` holds the page base: the upper bits of the address with the low `PAGE_W` bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStrb | input | 1 | Opens a page write; loads the address |
| startAddr | input | ADDR_W | Word address of the first data byte |
| byteStrb | input | 1 | One data byte is valid |
| byteData | input | 8 | Data byte |
| stopStrb | input | 1 | End of transfer; starts the commit |
| writeProtect | input | 1 | 1 makes the upper half of the array read-only |
| rdAddr | input | ADDR_W | Array read address |
| rdData | output | 8 | Array byte at rdAddr (combinational) |
| busy | output | 1 | Program cycle in progress |
| curAddr | output | ADDR_W | Shared word address counter |
| progEn | output | 1 | One-cycle program strobe to the array |
| progAddr | output | ADDR_W | Page base address of the program |
| progByteEn | output | 2**PAGE_W | Per-slot write enables |
| progData | output | 8*2**PAGE_W | Buffered page data, slot i at bits 8i+7:8i |

## Verification
The bench builds the block with `ADDR_W` at 8, `PAGE_W` at 5 and `WRITE_CYCLES` at 12. That gives eight pages of 32 bytes, so after each transfer the bench can compare a whole page against its model. With a 12-cycle busy window, every busy period can be counted edge by edge. With these values the random stream of start addresses, lengths from 0 to 40 and random protect levels covers the page wraparound, the overflow past 32 bytes, empty transfers and both halves of the array. Strobes injected in the middle of the busy window test that inputs are ignored while busy.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  // strobes from the sequencing control to the buffer datapath
  typedef struct packed {
    logic loadAddr;   // open a page: load address, clear slot enables
    logic storeByte;  // latch one data byte and advance the in-page offset
    logic commit;     // program buffered slots into the array this cycle
  } pwbStrobes_t;

endpackage

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int WRITE_CYCLES = 500000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startStrb,
  input  logic        byteStrb,
  input  logic        stopStrb,
  input  logic        anyByte,
  input  logic        protectHit,
  output pwbStrobes_t strobes,
  output logic        busy
);

  localparam int TMR_W = $clog2(WRITE_CYCLES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_PROG} state_t;

  state_t            state, stateNext;
  logic [TMR_W-1:0]  timer;
  logic              commitQ;
  logic              goProg;

  assign goProg = (state == ST_FILL) && stopStrb && !startStrb && anyByte && !protectHit;

  always_comb begin
    strobes.loadAddr  = startStrb && (state != ST_PROG);
    strobes.storeByte = byteStrb && (state == ST_FILL) && !startStrb && !stopStrb;
    strobes.commit    = commitQ;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (startStrb) stateNext = ST_FILL;
      ST_FILL: begin
        if (startStrb)     stateNext = ST_FILL;
        else if (goProg)   stateNext = ST_PROG;
        else if (stopStrb) stateNext = ST_IDLE;
      end
      ST_PROG: if (timer == '0) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      timer   <= '0;
      commitQ <= 1'b0;
    end else begin
      state   <= stateNext;
      commitQ <= goProg;
      if (goProg)
        timer <= TMR_W'(WRITE_CYCLES - 1);
      else if (state == ST_PROG && timer != '0)
        timer <= timer - 1'b1;
    end
  end

  assign busy = (state == ST_PROG);

endmodule

// File: rtl/pwb_datapath.sv
module pwb_datapath
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pwbStrobes_t                   strobes,
  input  logic [ADDR_W-1:0]             startAddr,
  input  logic [7:0]                    byteData,
  input  logic                          writeProtect,
  output logic [ADDR_W-1:0]             curAddr,
  output logic                          anyByte,
  output logic                          protectHit,
  output logic [ADDR_W-1:0]             progAddr,
  output logic [(1<<PAGE_W)-1:0]        progByteEn,
  output logic [8*(1<<PAGE_W)-1:0]      progData
);

  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [PAGE_W-1:0]     slotOff;
  logic [PAGE_W-1:0]     slotNext;
  logic [PAGE_BYTES-1:0] slotEn;

  assign slotOff  = curAddr[PAGE_W-1:0];
  assign slotNext = slotOff + PAGE_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      slotEn  <= '0;
    end else if (strobes.loadAddr) begin
      curAddr <= startAddr;
      slotEn  <= '0;
    end else if (strobes.storeByte) begin
      curAddr          <= {curAddr[ADDR_W-1:PAGE_W], slotNext};
      slotEn[slotOff]  <= 1'b1;
    end
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)
        progData[8*i +: 8] <= 8'h00;
      else if (strobes.storeByte && slotOff == PAGE_W'(i))
        progData[8*i +: 8] <= byteData;
    end
  end

  assign anyByte    = |slotEn;
  assign protectHit = writeProtect && curAddr[ADDR_W-1];
  assign progAddr   = {curAddr[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
  assign progByteEn = slotEn;

endmodule

// File: rtl/pwb_mem.sv
module pwb_mem #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      progEn,
  input  logic [ADDR_W-1:0]         progAddr,
  input  logic [(1<<PAGE_W)-1:0]    progByteEn,
  input  logic [8*(1<<PAGE_W)-1:0]  progData,
  input  logic [ADDR_W-1:0]         rdAddr,
  output logic [7:0]                rdData
);

  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) cells[k] <= 8'h00;
    end else if (progEn) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (progByteEn[i])
          cells[{progAddr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= progData[8*i +: 8];
    end
  end

  assign rdData = cells[rdAddr];

endmodule

// File: rtl/pwb_sequencer.sv
module pwb_sequencer
  import pwb_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 500000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      startStrb,
  input  logic [ADDR_W-1:0]         startAddr,
  input  logic                      byteStrb,
  input  logic [7:0]                byteData,
  input  logic                      stopStrb,
  input  logic                      writeProtect,
  input  logic [ADDR_W-1:0]         rdAddr,
  output logic [7:0]                rdData,
  output logic                      busy,
  output logic [ADDR_W-1:0]         curAddr,
  output logic                      progEn,
  output logic [ADDR_W-1:0]         progAddr,
  output logic [(1<<PAGE_W)-1:0]    progByteEn,
  output logic [8*(1<<PAGE_W)-1:0]  progData
);

  pwbStrobes_t strobes;
  logic        anyByte;
  logic        protectHit;

  pwb_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startStrb  (startStrb),
    .byteStrb   (byteStrb),
    .stopStrb   (stopStrb),
    .anyByte    (anyByte),
    .protectHit (protectHit),
    .strobes    (strobes),
    .busy       (busy)
  );

  pwb_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) uPath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .startAddr    (startAddr),
    .byteData     (byteData),
    .writeProtect (writeProtect),
    .curAddr      (curAddr),
    .anyByte      (anyByte),
    .protectHit   (protectHit),
    .progAddr     (progAddr),
    .progByteEn   (progByteEn),
    .progData     (progData)
  );

  assign progEn = strobes.commit;

  pwb_mem #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) uMem (
    .clk        (clk),
    .rstN       (rstN),
    .progEn     (progEn),
    .progAddr   (progAddr),
    .progByteEn (progByteEn),
    .progData   (progData),
    .rdAddr     (rdAddr),
    .rdData     (rdData)
  );

endmodule

// File: rtl/pwb_sequencer_checker.sv
module pwb_sequencer_checker #(
  parameter int ADDR_W       = 10,
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 500000
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    startStrb,
  input logic                    writeProtect,
  input logic                    busy,
  input logic [ADDR_W-1:0]       curAddr,
  input logic                    progEn,
  input logic [ADDR_W-1:0]       progAddr,
  input logic [(1<<PAGE_W)-1:0]  progByteEn
);

  localparam int RUN_W = $clog2(WRITE_CYCLES + 2);

  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  assert_busy_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= RUN_W'(WRITE_CYCLES));

  assert_rise_commits_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> progEn);

  assert_commit_in_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    progEn |-> busy);

  assert_commit_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    progEn |=> !progEn);

  assert_enables_present_R8: assert property (@(posedge clk) disable iff (!rstN)
    progEn |-> (progByteEn != '0));

  assert_protect_block_R7: assert property (@(posedge clk) disable iff (!rstN)
    progEn |-> !($past(writeProtect) && progAddr[ADDR_W-1]));

  assert_addr_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(curAddr));

  assert_page_fixed_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(startStrb) |-> $stable(curAddr[ADDR_W-1:PAGE_W]));

endmodule

bind pwb_sequencer pwb_sequencer_checker #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)
) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .startStrb    (startStrb),
  .writeProtect (writeProtect),
  .busy         (busy),
  .curAddr      (curAddr),
  .progEn       (progEn),
  .progAddr     (progAddr),
  .progByteEn   (progByteEn)
);

// File: tb/pwb_sequencer_test.sv
module pwb_sequencer_test;

  localparam int ADDR_W = 8;
  localparam int PAGE_W = 5;
  localparam int WC     = 12;
  localparam int PB     = 1 << PAGE_W;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               startStrb = 1'b0;
  logic [ADDR_W-1:0]  startAddr = '0;
  logic               byteStrb = 1'b0;
  logic [7:0]         byteData = '0;
  logic               stopStrb = 1'b0;
  logic               writeProtect = 1'b0;
  logic [ADDR_W-1:0]  rdAddr = '0;
  logic [7:0]         rdData;
  logic               busy;
  logic [ADDR_W-1:0]  curAddr;
  logic               progEn;
  logic [ADDR_W-1:0]  progAddr;
  logic [PB-1:0]      progByteEn;
  logic [8*PB-1:0]    progData;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 0;
  logic [7:0] expMem [1<<ADDR_W];

  always #2 clk = ~clk;

  pwb_sequencer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WC)) uut (
    .clk(clk), .rstN(rstN), .startStrb(startStrb), .startAddr(startAddr),
    .byteStrb(byteStrb), .byteData(byteData), .stopStrb(stopStrb),
    .writeProtect(writeProtect), .rdAddr(rdAddr), .rdData(rdData),
    .busy(busy), .curAddr(curAddr), .progEn(progEn), .progAddr(progAddr),
    .progByteEn(progByteEn), .progData(progData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] nextAddr(input logic [7:0] a);
    return {a[7:5], a[4:0] + 5'd1};
  endfunction

  task automatic checkPage(input logic [7:0] a, input string req);
    for (int k = 0; k < PB; k++) begin
      logic [7:0] ra;
      ra = {a[7:5], 5'(k)};
      rdAddr = ra;
      #0.1;
      check(rdData == expMem[ra], req, "array byte", rdData, expMem[ra]);
    end
  endtask

  // one complete transfer; mirrors the requirements in the bench model
  task automatic runTxn(input logic [7:0] a, input int n, input logic wp,
                        input bit noise, input string req);
    logic [7:0] pg [PB];
    logic [PB-1:0] mask;
    logic [7:0] cur;
    int busyCnt;
    bit willProg;
    mask = '0;
    cur  = a;
    @(negedge clk);
    writeProtect = wp; startStrb = 1'b1; startAddr = a;
    @(negedge clk);
    startStrb = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      byteStrb = 1'b1; byteData = d;
      pg[cur[4:0]] = d; mask[cur[4:0]] = 1'b1;
      cur = nextAddr(cur);
      @(negedge clk);
      byteStrb = 1'b0;
    end
    rdAddr = a;
    #0.1;
    check(rdData == expMem[a], "R4", "array before stop", rdData, expMem[a]);
    check(curAddr == cur, "R2", "address counter", curAddr, cur);
    willProg = (n > 0) && !(wp && a[7]);
    stopStrb = 1'b1;
    @(negedge clk);
    stopStrb = 1'b0;
    if (willProg) begin
      check(progEn == 1'b1, "R11", "commit strobe", progEn, 1);
      check(progAddr == {a[7:5], 5'd0}, "R11", "page base", progAddr, {a[7:5], 5'd0});
      check(progByteEn == mask, "R8", "slot enables", progByteEn, mask);
      for (int k = 0; k < PB; k++)
        if (mask[k]) expMem[{a[7:5], 5'(k)}] = pg[k];
    end
    busyCnt = 0;
    while (busy && busyCnt < 1000) begin
      busyCnt++;
      if (noise && busyCnt == 2) begin
        startStrb = 1'b1; startAddr = ~a; byteStrb = 1'b1; byteData = 8'h5A; stopStrb = 1'b1;
      end
      @(negedge clk);
      startStrb = 1'b0; byteStrb = 1'b0; stopStrb = 1'b0;
      if (busyCnt == 1)
        check(progEn == 1'b0, "R11", "commit width", progEn, 0);
    end
    check(busyCnt == (willProg ? WC : 0), req, "busy cycles", busyCnt, willProg ? WC : 0);
    check(curAddr == cur, noise ? "R6" : "R10", "address after write", curAddr, cur);
    checkPage(a, req);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nFails++;
      $display("FAIL R5 watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int k = 0; k < (1 << ADDR_W); k++) expMem[k] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(progEn == 1'b0, "R1", "commit after reset", progEn, 0);
    check(curAddr == '0, "R1", "counter after reset", curAddr, 0);
    checkPage(8'h40, "R1");

    runTxn(8'h05, 1, 1'b0, 1'b0, "R5");       // single byte
    runTxn(8'h3E, 4, 1'b0, 1'b0, "R2");       // offset wrap inside page
    runTxn(8'h20, 40, 1'b0, 1'b0, "R3");      // overflow past one page
    runTxn(8'h61, 3, 1'b0, 1'b0, "R8");       // partial page
    runTxn(8'h10, 0, 1'b0, 1'b0, "R9");       // empty transfer
    runTxn(8'hA0, 5, 1'b1, 1'b0, "R7");       // protected upper page
    runTxn(8'h48, 5, 1'b1, 1'b0, "R7");       // lower page under protect
    runTxn(8'hC3, 6, 1'b0, 1'b0, "R7");       // upper page unprotected
    runTxn(8'h87, 7, 1'b0, 1'b1, "R6");       // strobes during busy
    runTxn(8'h5F, 2, 1'b0, 1'b0, "R10");      // last slot wraps counter

    for (int t = 0; t < 40; t++)
      runTxn(8'($urandom), $urandom_range(0, 40), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), "R4");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule